// File: doc/BRIEF.md
# Synchronous Burst Static RAM Core

This block is a single-clock static RAM with a short linear burst. The data word is split into byte lanes. By default there are four lanes of 9 bits over a 256-word array, and the address width is a parameter, so a deeper array is a parameter change.

A cycle that loads an address is opened by one of two active-low strobes: a processor strobe and a controller strobe. The address is loaded only when the three chip enables select the device. The two low address bits then seed a 2-bit beat counter. While a burst is open, cycles without a strobe continue it. The advance input steps the beat counter, and the write controls decide whether the cycle reads or writes. Writes are either global (every lane) or per-lane under a byte-write enable.

Read data comes back on a separate output bus with a valid flag. There is no ready input. The consumer must take each beat in the cycle where `rvalid` is high, because a static RAM cannot hold off its own output. Data is never repeated unless the burst address is held. An asynchronous output enable gates the valid flag and the data. A sleep input freezes all state and silences the outputs.

Top module: `bsram_core`

## Requirements
- R1: After reset the device is deselected. `rvalid` is low, and cycles without a strobe cause no read and no write.
- R2: A strobe cycle loads a new address only when `chip_en1_n`=0, `chip_en2`=1 and `chip_en3_n`=0. Otherwise it deselects the device. A load copies `addr[1:0]` into the beat counter and keeps `addr[ADDR_W-1:2]` as the fixed upper address.
- R3: When both strobes are low and the processor strobe is honoured, the cycle is a read and the write controls are ignored. A processor-strobe load is always a read. A controller-strobe load reads or writes as the write controls say.
- R4: The processor strobe has no effect while `chip_en1_n` is high. An open burst continues as if no strobe were present.
- R5: In cycles without an honoured strobe, the chip enables have no effect on an open burst.
- R6: In a burst cycle with `adv_n` low, the beat counter steps +1 and wraps from 3 to 0. The upper address bits stay fixed. With `adv_n` high the address holds.
- R7: With `gwr_n` low, all lanes are written from `wdata`, whatever `bwr_n` and `lane_sel_n` are. Lane i is `wdata[9i+8:9i]` with the default lane width.
- R8: With `gwr_n` high and `bwr_n` low, only the lanes whose `lane_sel_n` bit is 0 are written. With both `gwr_n` and `bwr_n` high, nothing is written and the cycle is a read.
- R9: After the clock edge of a read cycle, `rdata` holds the word at that cycle's address, as it was before any write at the same edge. `rvalid` is low after a write cycle.
- R10: `oe_n` acts without the clock. While it is high, `rvalid` is 0 and `rdata` is 0.
- R11: The first read cycle after the deselected state (including after reset) is not shown: `rvalid` stays low for it. A following read in the same burst is shown.
- R12: While `sleep` is high, every synchronous control is ignored, `rvalid` is 0, and the array, address and burst state are kept for when sleep ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| chip_en2 | input | 1 | Chip enable 2, active high |
| chip_en3_n | input | 1 | Chip enable 3, active low |
| proc_stb_n | input | 1 | Processor address strobe, active low, higher priority |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| rdata | output | LANES*LANE_W | Read data, zero when not valid |
| rvalid | output | 1 | Read beat valid |

## Verification
A wrong beat counter or a lost upper address shows up in the very next read beat as data from the wrong word. The bench steps through all four beats, wraps them, and compares each with its reference copy. A wrong strobe priority or a missed lane decode is harmless at first: the write goes to the wrong place or is dropped, and it becomes visible only when that word is read back. So each write scenario ends with a read of the affected word. Mask and sleep errors show at once as a wrong `rvalid` in the cycle after the edge, or within a nanosecond of an `oe_n` change.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;
endpackage

// File: rtl/bsram_ctrl.sv
// Strobe arbitration, device select, address register and beat counter.
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              chip_en1_n,
  input  logic              chip_en2,
  input  logic              chip_en3_n,
  input  logic              proc_stb_n,
  input  logic              ctl_stb_n,
  input  logic              adv_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  output cyc_e              kind,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              fresh
);
  localparam int HI_W = ADDR_W - 2;

  logic            act_q, act_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic [1:0]      cnt_q, cnt_d;
  logic            p_take, c_take, load, sel;

  always_comb begin
    p_take = !proc_stb_n && !chip_en1_n;
    c_take = !ctl_stb_n && !p_take;
    load   = p_take || c_take;
    sel    = !chip_en1_n && chip_en2 && !chip_en3_n;
    kind   = CYC_IDLE;
    act_d  = act_q;
    hi_d   = hi_q;
    cnt_d  = cnt_q;
    fresh  = 1'b0;
    if (sleep) begin
      kind = CYC_IDLE;
    end else if (load) begin
      act_d = sel;
      if (sel) begin
        hi_d  = addr[ADDR_W-1:2];
        cnt_d = addr[1:0];
        fresh = !act_q;
        kind  = (c_take && wr_req) ? CYC_WRITE : CYC_READ;
      end
    end else if (act_q) begin
      if (!adv_n) cnt_d = cnt_q + 2'd1;
      kind = wr_req ? CYC_WRITE : CYC_READ;
    end
    eff_addr = {hi_d, cnt_d};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      hi_q  <= '0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      hi_q  <= hi_d;
      cnt_q <= cnt_d;
    end
  end

  p_load_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && sel && !sleep) |=> (cnt_q == $past(addr[1:0]) && hi_q == $past(addr[ADDR_W-1:2])));
  p_proc_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !proc_stb_n && !chip_en1_n && chip_en2 && !chip_en3_n) |-> (kind == CYC_READ));
  p_ce_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !load && !sleep) |=> act_q);
  p_adv_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !load && !sleep && !adv_n) |=> (cnt_q == $past(cnt_q) + 2'd1));
  p_hi_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !load && !sleep) |=> $stable(hi_q));
  p_sleep_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(act_q) && $stable(cnt_q) && $stable(hi_q)));
endmodule

// File: rtl/bsram_lanes.sv
// Write-lane decode: global write overrides the byte-write path.
module bsram_lanes #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gwr_n,
  input  logic             bwr_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic [LANES-1:0] lane_we,
  output logic             wr_req
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = !gwr_n || (!bwr_n && !lane_sel_n[g]);
  end
  assign wr_req = |lane_we;

  p_gw_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gwr_n |-> (&lane_we));
  p_bwe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gwr_n && bwr_n) |-> !wr_req);
endmodule

// File: rtl/bsram_array.sv
// Lane-writable storage with a registered read port (read-before-write).
module bsram_array
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  cyc_e                    kind,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] dout
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANES-1:0][LANE_W-1:0] mem [DEPTH];
  logic [LANES-1:0][LANE_W-1:0] dout_q;

  always_ff @(posedge clk) begin
    if (kind == CYC_WRITE) begin
      for (int i = 0; i < LANES; i++) begin
        if (lane_we[i]) mem[addr][i] <= wdata[i*LANE_W +: LANE_W];
      end
    end
    if (kind == CYC_READ) dout_q <= mem[addr];
  end

  assign dout = dout_q;

  p_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != CYC_READ) |=> $stable(dout_q));
endmodule

// File: rtl/bsram_core.sv
module bsram_core
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    chip_en1_n,
  input  logic                    chip_en2,
  input  logic                    chip_en3_n,
  input  logic                    proc_stb_n,
  input  logic                    ctl_stb_n,
  input  logic                    adv_n,
  input  logic                    gwr_n,
  input  logic                    bwr_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);
  localparam int DW = LANES * LANE_W;

  cyc_e              kind;
  logic [ADDR_W-1:0] eff_addr;
  logic              fresh;
  logic [LANES-1:0]  lane_we;
  logic              wr_req;
  logic [DW-1:0]     dout;
  logic              vld_q, msk_q;

  bsram_lanes #(.LANES(LANES)) u_lanes (
    .clk(clk), .rst_n(rst_n), .gwr_n(gwr_n), .bwr_n(bwr_n),
    .lane_sel_n(lane_sel_n), .lane_we(lane_we), .wr_req(wr_req));

  bsram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep(sleep),
    .chip_en1_n(chip_en1_n), .chip_en2(chip_en2), .chip_en3_n(chip_en3_n),
    .proc_stb_n(proc_stb_n), .ctl_stb_n(ctl_stb_n), .adv_n(adv_n),
    .wr_req(wr_req), .addr(addr), .kind(kind), .eff_addr(eff_addr), .fresh(fresh));

  bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .kind(kind), .addr(eff_addr),
    .lane_we(lane_we), .wdata(wdata), .dout(dout));

  // Output qualification: a beat is shown unless it is the first read
  // after deselect, output enable is off, or the block sleeps.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      msk_q <= 1'b0;
    end else if (!sleep) begin
      vld_q <= (kind == CYC_READ);
      msk_q <= fresh;
    end
  end

  assign rvalid = vld_q && !msk_q && !oe_n && !sleep;
  assign rdata  = rvalid ? dout : '0;

  p_no_data_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_WRITE && !sleep) |=> !rvalid);
  p_oe_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!rvalid && rdata == '0));
  p_first_hidden_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh && kind == CYC_READ) |=> !rvalid);
  p_sleep_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rvalid);
endmodule

// File: tb/bsram_core_test.sv
module bsram_core_test;
  localparam int ADDR_W = 8;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DW     = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_en1_n, chip_en2, chip_en3_n, proc_stb_n, ctl_stb_n, adv_n;
  logic gwr_n, bwr_n, oe_n, sleep;
  logic [LANES-1:0]  lane_sel_n;
  logic [ADDR_W-1:0] addr;
  logic [DW-1:0]     wdata, rdata;
  logic              rvalid;

  logic [DW-1:0] refm [DEPTH];
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  bsram_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) uut (
    .clk(clk), .rst_n(rst_n), .chip_en1_n(chip_en1_n), .chip_en2(chip_en2),
    .chip_en3_n(chip_en3_n), .proc_stb_n(proc_stb_n), .ctl_stb_n(ctl_stb_n),
    .adv_n(adv_n), .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_sel_n(lane_sel_n),
    .addr(addr), .wdata(wdata), .oe_n(oe_n), .sleep(sleep),
    .rdata(rdata), .rvalid(rvalid));

  task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_read(string req, logic [ADDR_W-1:0] a);
    chk(req, {{(DW-1){1'b0}}, rvalid}, 1);
    chk(req, rdata, refm[a]);
  endtask

  task automatic idle_in();
    chip_en1_n = 1'b1; chip_en2 = 1'b0; chip_en3_n = 1'b1;
    proc_stb_n = 1'b1; ctl_stb_n = 1'b1; adv_n = 1'b1;
    gwr_n = 1'b1; bwr_n = 1'b1; lane_sel_n = '1;
    addr = '0; wdata = '0;
  endtask

  task automatic sel_on();
    chip_en1_n = 1'b0; chip_en2 = 1'b1; chip_en3_n = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic ctl_write_all(logic [ADDR_W-1:0] a, logic [DW-1:0] d);
    idle_in(); sel_on(); ctl_stb_n = 1'b0; addr = a; gwr_n = 1'b0; wdata = d;
    tick(); refm[a] = d; idle_in();
  endtask

  task automatic proc_read(logic [ADDR_W-1:0] a);
    idle_in(); sel_on(); proc_stb_n = 1'b0; addr = a;
    tick(); idle_in();
  endtask

  task automatic t_reset();
    chk("R1 rvalid after reset", {{(DW-1){1'b0}}, rvalid}, 0);
    adv_n = 1'b0; tick(); adv_n = 1'b1;
    chk("R1 idle cycle while deselected", {{(DW-1){1'b0}}, rvalid}, 0);
  endtask

  task automatic t_global_write();
    ctl_write_all(8'h10, 36'h1_2345_6789);
    chk("R9 no beat after write", {{(DW-1){1'b0}}, rvalid}, 0);
    // global write must override byte enable and selects
    idle_in(); sel_on(); ctl_stb_n = 1'b0; addr = 8'h11; gwr_n = 1'b0;
    bwr_n = 1'b0; lane_sel_n = 4'b0111; wdata = 36'hA_BCDE_F012;
    tick(); refm[8'h11] = 36'hA_BCDE_F012; idle_in();
    proc_read(8'h10); chk_read("R7 R9 global write readback", 8'h10);
    proc_read(8'h11); chk_read("R7 override of lane selects", 8'h11);
  endtask

  task automatic t_byte_write();
    idle_in(); sel_on(); ctl_stb_n = 1'b0; addr = 8'h10; bwr_n = 1'b0;
    lane_sel_n = 4'b1010; wdata = 36'hF_FFFF_FFFF;
    tick(); idle_in();
    refm[8'h10][8:0]   = 9'h1FF;
    refm[8'h10][26:18] = 9'h1FF;
    // byte enable off: selects ignored, the load is a read
    sel_on(); ctl_stb_n = 1'b0; addr = 8'h10; lane_sel_n = 4'b0000;
    wdata = 36'h0; tick(); idle_in();
    chk_read("R8 disabled byte write reads", 8'h10);
    proc_read(8'h10); chk_read("R8 lanes 0 and 2 only", 8'h10);
  endtask

  task automatic t_collision();
    ctl_write_all(8'h20, 36'h5_5555_AAAA);
    idle_in(); sel_on(); proc_stb_n = 1'b0; ctl_stb_n = 1'b0; addr = 8'h20;
    gwr_n = 1'b0; wdata = 36'h0_DEAD_BEEF;
    tick(); idle_in();
    chk_read("R3 collision is a read", 8'h20);
    tick(); chk_read("R3 collision wrote nothing", 8'h20);
  endtask

  task automatic t_proc_gated();
    idle_in(); proc_stb_n = 1'b0; chip_en1_n = 1'b1; addr = 8'h30;
    tick(); idle_in();
    chk_read("R4 processor strobe ignored", 8'h20);
  endtask

  task automatic t_ce_ignored();
    idle_in(); chip_en1_n = 1'b1; chip_en2 = 1'b0; chip_en3_n = 1'b1;
    tick(); chk_read("R5 enables ignored in burst", 8'h20);
  endtask

  task automatic t_burst();
    ctl_write_all(8'h42, 36'h0_0000_0001);
    for (int k = 1; k < 4; k++) begin
      logic [ADDR_W-1:0] a;
      a = {6'h10, 2'(2 + k)};
      idle_in(); adv_n = 1'b0; gwr_n = 1'b0; wdata = 36'(k * 36'h1_1111_1111);
      tick(); refm[a] = 36'(k * 36'h1_1111_1111);
    end
    idle_in();
    proc_read(8'h42); chk_read("R2 R6 burst beat 0", 8'h42);
    adv_n = 1'b0; tick(); chk_read("R6 burst beat 1", 8'h43);
    adv_n = 1'b0; tick(); chk_read("R6 burst wrap beat 2", 8'h40);
    adv_n = 1'b0; tick(); chk_read("R6 burst beat 3", 8'h41);
    adv_n = 1'b1; tick(); chk_read("R6 hold without advance", 8'h41);
  endtask

  task automatic t_mask();
    idle_in(); chip_en1_n = 1'b0; ctl_stb_n = 1'b0;
    tick(); idle_in();
    chk("R2 deselect load", {{(DW-1){1'b0}}, rvalid}, 0);
    tick(); chk("R1 stays deselected", {{(DW-1){1'b0}}, rvalid}, 0);
    proc_read(8'h42);
    chk("R11 first read masked", {{(DW-1){1'b0}}, rvalid}, 0);
    tick(); chk_read("R11 next beat shown", 8'h42);
  endtask

  task automatic t_oe();
    oe_n = 1'b1; #1;
    chk("R10 oe off rvalid", {{(DW-1){1'b0}}, rvalid}, 0);
    chk("R10 oe off rdata", rdata, 0);
    oe_n = 1'b0; #1;
    chk_read("R10 oe back on", 8'h42);
  endtask

  task automatic t_sleep();
    idle_in(); adv_n = 1'b0; tick(); idle_in();
    chk_read("R6 advance before sleep", 8'h43);
    sleep = 1'b1; #1;
    chk("R12 sleep silences", {{(DW-1){1'b0}}, rvalid}, 0);
    sel_on(); ctl_stb_n = 1'b0; addr = 8'h40; gwr_n = 1'b0;
    wdata = 36'h7_7777_7777;
    tick();
    chk("R12 no beat in sleep", {{(DW-1){1'b0}}, rvalid}, 0);
    idle_in(); adv_n = 1'b0; tick();
    idle_in(); sleep = 1'b0;
    tick(); chk_read("R12 burst address kept", 8'h43);
    proc_read(8'h40); chk_read("R12 contents kept", 8'h40);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle_in(); oe_n = 1'b0; sleep = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_global_write();
    t_byte_write();
    t_collision();
    t_proc_gated();
    t_ce_ignored();
    t_burst();
    t_mask();
    t_oe();
    t_sleep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule